// File: doc/BRIEF.md
# Twin Prescaled Period-Match Timer

This block holds two independent up-counting timers. Both run from one input clock, and each has its own clock divider. On every divided tick a timer's counter moves up by one. When the counter equals that channel's period value, it returns to zero on the next tick and sets a sticky match flag. The PWM interrupt logic uses that flag as a period-boundary event. The count values are also driven out, so that downstream compare logic can use them.

Software configures each channel with one write. The write selects the channel and supplies its period, its divider select and its run enable together. Each flag is cleared by its own write-one-to-clear strobe. Each channel is controlled by a two-state machine:
- ST_HALT: the counter and the divider hold their values.
- ST_COUNT: the divider advances and the counter steps on each tick.

There are two transitions. EN_ON (a write with enable 1) goes from ST_HALT to ST_COUNT. EN_OFF (a write with enable 0) goes from ST_COUNT to ST_HALT. Reset returns the machine to ST_HALT.

Top module: `tmr_pair`

## Requirements
- R1: The two channels are independent. A write with `wr_en`=1 loads only the channel numbered by `wr_sel` (0 or 1), taking `wr_data[9:0]` as its period, `wr_data[11:10]` as its divider select and `wr_data[12]` as its enable.
- R2: Divider select 00 divides by 2, 01 by 8, 10 by 32 and 11 by 64. With divide-by-N, the first counter step comes N cycles after the edge that applied the enabling write, and later steps come every N cycles.
- R3: On a tick, a counter below its period increases by one. A counter equal to its period returns to 0.
- R4: The tick that returns the counter from its period to 0 also sets that channel's `match_flag` bit. From enable to the first flag takes (period+1)*N cycles.
- R5: A set flag stays set until `flag_clr` for that channel is 1 on a clock edge. The clear takes effect on that edge.
- R6: When a flag-setting tick and a clear occur on the same edge, the flag ends up set.
- R7: A write with enable 0 freezes both the counter and the divider at their current values. A later write with enable 1 resumes counting from those same values.
- R8: With period 0, the counter stays at 0 and the flag is set on every tick.
- R9: A synchronous reset clears the counters, the dividers, the flags, the enables and the configuration.
- R10: `count_out` shows channel 0 in bits [9:0] and channel 1 in bits [19:10]. Each value is updated on the edge where the counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer input clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 1 | Channel number for the write |
| wr_data | input | 13 | {enable, divider select[1:0], period[9:0]} |
| flag_clr | input | 2 | Per-channel write-one-to-clear for the match flags |
| count_out | output | 20 | Counter values of both channels |
| match_flag | output | 2 | Sticky period-match flags |

## Verification
The bench uses the default parameters: a 10-bit counter and two channels. Small period values (0 to 3) make the wrap point and the flag set reachable within tens of cycles. The bench exercises all four divider ratios, including divide-by-64, and with them both channels running side by side at different rates. The short periods also let it schedule a clear on exactly the edge where a wrap sets the flag, and let it freeze a channel partway between ticks and then resume it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int PRE_W = 6;

    typedef enum logic [0:0] {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } chan_state_e;

    typedef enum logic [1:0] {
        DIV2  = 2'd0,
        DIV8  = 2'd1,
        DIV32 = 2'd2,
        DIV64 = 2'd3
    } pre_sel_e;

    // terminal value of the divider count for a given select
    function automatic logic [PRE_W-1:0] pre_last(input logic [1:0] sel);
        logic [PRE_W-1:0] lim;
        unique case (pre_sel_e'(sel))
            DIV2:    lim = PRE_W'(1);
            DIV8:    lim = PRE_W'(7);
            DIV32:   lim = PRE_W'(31);
            DIV64:   lim = PRE_W'(63);
            default: lim = PRE_W'(1);
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;

    always_comb begin
        lim  = pre_last(sel);
        tick = run && (pre_q >= lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else if (run) begin
            if (tick) pre_q <= '0;
            else      pre_q <= pre_q + PRE_W'(1);
        end
    end

    AST_PRE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(pre_q)); // R7

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R2

endmodule

// File: rtl/tmr_cfg_reg.sv
module tmr_cfg_reg #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W+1:0] data,
    output logic [CNT_W-1:0] period,
    output logic [1:0]       sel
);

    logic [CNT_W-1:0] period_q;
    logic [1:0]       sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= '0;
            sel_q    <= 2'd0;
        end else if (load) begin
            period_q <= data[CNT_W-1:0];
            sel_q    <= data[CNT_W+1:CNT_W];
        end
    end

    always_comb begin
        period = period_q;
        sel    = sel_q;
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable({period_q, sel_q})); // R1

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_wr,
    input  logic             en_val,
    input  logic [CNT_W-1:0] period,
    input  logic [1:0]       sel,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             flag
);

    chan_state_e      state_q, state_d;
    logic             run;
    logic             tick;
    logic             at_top;
    logic             wrap;
    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;

    // next-state logic: EN_ON and EN_OFF transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (en_wr && en_val)  state_d = ST_COUNT;
            ST_COUNT: if (en_wr && !en_val) state_d = ST_HALT;
            default:  state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HALT;
        else     state_q <= state_d;
    end

    assign run = (state_q == ST_COUNT);

    tmr_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .sel  (sel),
        .tick (tick)
    );

    always_comb begin
        at_top = (cnt_q == period);
        wrap   = tick && at_top;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (at_top) cnt_q <= '0;
            else        cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // set has priority over clear
    always_ff @(posedge clk) begin
        if (rst)       flag_q <= 1'b0;
        else if (wrap) flag_q <= 1'b1;
        else if (clr)  flag_q <= 1'b0;
    end

    // output process
    always_comb begin
        cnt  = cnt_q;
        flag = flag_q;
    end

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HALT) |=> $stable(cnt_q)); // R7

    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        (tick && !at_top) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R3

    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt_q == '0 && flag_q)); // R4

    AST_CLR_WINS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (clr && !wrap) |=> !flag_q); // R5

    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
        (clr && wrap) |=> flag_q); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr) |=> flag_q); // R5

    AST_ZERO_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (period == '0 && cnt_q == '0 && tick) |=> (cnt_q == '0 && flag_q)); // R8

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair #(
    parameter int CNT_W  = 10,
    parameter int NUM_CH = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [$clog2(NUM_CH)-1:0] wr_sel,
    input  logic [CNT_W+2:0]          wr_data,
    input  logic [NUM_CH-1:0]         flag_clr,
    output logic [NUM_CH*CNT_W-1:0]   count_out,
    output logic [NUM_CH-1:0]         match_flag
);

    localparam int SEL_W  = $clog2(NUM_CH);
    localparam int EN_BIT = CNT_W + 2;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic             load;
        logic [CNT_W-1:0] period;
        logic [1:0]       sel;

        assign load = wr_en && (wr_sel == SEL_W'(ch));

        tmr_cfg_reg #(.CNT_W(CNT_W)) u_cfg (
            .clk    (clk),
            .rst    (rst),
            .load   (load),
            .data   (wr_data[CNT_W+1:0]),
            .period (period),
            .sel    (sel)
        );

        tmr_channel #(.CNT_W(CNT_W)) u_chan (
            .clk    (clk),
            .rst    (rst),
            .en_wr  (load),
            .en_val (wr_data[EN_BIT]),
            .period (period),
            .sel    (sel),
            .clr    (flag_clr[ch]),
            .cnt    (count_out[ch*CNT_W +: CNT_W]),
            .flag   (match_flag[ch])
        );
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (count_out == '0 && match_flag == '0)); // R9

endmodule

// File: tb/sim_tmr_pair.sv
module sim_tmr_pair;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;
    localparam int CW         = 10;

    typedef struct {
        int    cyc;
        int    ch;
        int    cnt;
        bit    flg;
        string req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [0:0]    wr_sel = 1'b0;
    logic [12:0]   wr_data = '0;
    logic [1:0]    flag_clr = '0;
    logic [19:0]   count_out;
    logic [1:0]    match_flag;

    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    exp_t q[$];
    exp_t cur;

    tmr_pair u0 (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .flag_clr   (flag_clr),
        .count_out  (count_out),
        .match_flag (match_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(input int c, input int ch, input int cnt, input bit flg, input string req);
        exp_t e;
        e.cyc = c; e.ch = ch; e.cnt = cnt; e.flg = flg; e.req = req;
        q.push_back(e);
    endtask

    // monitor: pops due items and compares at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            cur = q.pop_front();
            n_cmp++;
            if (cur.cyc < cyc) begin
                n_bad++;
                $display("FAIL %s: check for cycle %0d missed (now %0d), expected cnt=%0d flag=%0d",
                         cur.req, cur.cyc, cyc, cur.cnt, cur.flg);
            end else if (count_out[cur.ch*CW +: CW] != CW'(cur.cnt) || match_flag[cur.ch] != cur.flg) begin
                n_bad++;
                $display("FAIL %s: ch%0d cycle %0d actual cnt=%0d flag=%0d expected cnt=%0d flag=%0d",
                         cur.req, cur.ch, cyc, count_out[cur.ch*CW +: CW], match_flag[cur.ch],
                         cur.cnt, cur.flg);
            end
        end
    end

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
    endtask

    task automatic wait_until(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // all driving tasks start and end on a falling edge
    task automatic do_reset();
        int c;
        drain();
        c = cyc;
        rst = 1'b1;
        expect_at(c + 2, 0, 0, 1'b0, "R9");
        expect_at(c + 2, 1, 0, 1'b0, "R9");
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cfg_write(input int ch, input bit en, input int psel, input int per, output int applied);
        wr_en   = 1'b1;
        wr_sel  = 1'(ch);
        wr_data = {en, 2'(psel), 10'(per)};
        applied = cyc + 1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_flag(input int ch);
        flag_clr = 2'(1 << ch);
        @(negedge clk);
        flag_clr = '0;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        int e0, a0, c0, r0, dummy;
        @(negedge clk);
        @(negedge clk);
        do_reset();

        // ch0: divide-by-2, period 3
        cfg_write(0, 1'b1, 0, 3, e0);
        expect_at(e0 + 2,  0, 1, 1'b0, "R2");
        expect_at(e0 + 7,  0, 3, 1'b0, "R3");
        expect_at(e0 + 8,  0, 0, 1'b1, "R4");
        expect_at(e0 + 8,  1, 0, 1'b0, "R1");
        expect_at(e0 + 20, 0, 2, 1'b1, "R5");
        expect_at(e0 + 22, 0, 3, 1'b0, "R5");
        expect_at(e0 + 24, 0, 0, 1'b1, "R4");
        expect_at(e0 + 32, 0, 0, 1'b1, "R6");
        expect_at(e0 + 33, 0, 0, 1'b1, "R6");
        expect_at(e0 + 34, 0, 1, 1'b0, "R5");
        expect_at(e0 + 40, 0, 1, 1'b0, "R7");
        expect_at(e0 + 45, 0, 1, 1'b0, "R7");
        expect_at(e0 + 46, 0, 2, 1'b0, "R7");
        expect_at(e0 + 50, 0, 0, 1'b1, "R7");
        wait_until(e0 + 21); clear_flag(0);            // clear lands on edge 22
        wait_until(e0 + 31); clear_flag(0);            // clear on wrap edge 32
        wait_until(e0 + 33); clear_flag(0);            // clear on edge 34
        wait_until(e0 + 34); cfg_write(0, 1'b0, 0, 3, dummy);  // freeze on edge 35
        wait_until(e0 + 44); cfg_write(0, 1'b1, 0, 3, dummy);  // resume on edge 45

        // ch0 divide-by-8 period 2, ch1 divide-by-32 period 1
        do_reset();
        cfg_write(0, 1'b1, 1, 2, a0);
        expect_at(a0 + 8,  0, 1, 1'b0, "R2");
        expect_at(a0 + 23, 0, 2, 1'b0, "R10");
        expect_at(a0 + 24, 0, 0, 1'b1, "R4");
        expect_at(a0 + 33, 1, 1, 1'b0, "R2");
        expect_at(a0 + 48, 0, 0, 1'b1, "R3");
        expect_at(a0 + 64, 1, 1, 1'b0, "R10");
        expect_at(a0 + 65, 1, 0, 1'b1, "R4");
        cfg_write(1, 1'b1, 2, 1, dummy);

        // ch1 divide-by-64 with period 0
        do_reset();
        cfg_write(1, 1'b1, 3, 0, c0);
        expect_at(c0 + 1,   1, 0, 1'b0, "R8");
        expect_at(c0 + 63,  1, 0, 1'b0, "R2");
        expect_at(c0 + 64,  1, 0, 1'b1, "R8");
        expect_at(c0 + 65,  1, 0, 1'b0, "R5");
        expect_at(c0 + 127, 1, 0, 1'b0, "R8");
        expect_at(c0 + 128, 1, 0, 1'b1, "R8");
        expect_at(c0 + 128, 0, 0, 1'b0, "R1");
        wait_until(c0 + 64); clear_flag(1);

        // reset while a flag is set, then enables must stay cleared
        wait_until(c0 + 130);
        do_reset();
        r0 = cyc;
        expect_at(r0 + 70, 1, 0, 1'b0, "R9");
        expect_at(r0 + 70, 0, 0, 1'b0, "R9");
        drain();
        @(negedge clk);
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
            report();
            $finish;
        end
    end

endmodule